// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit load/store processor core. It completes every instruction in the same clock cycle that fetches it. The core reads its instruction word from a separate instruction-memory read port that is combinational. It reads and writes data through a second port, also combinational on the read side, with a write strobe that takes effect at the clock edge. Inside the core are:

- a program counter, which loads a new value on every clock edge;
- a 32-entry register file with two combinational read ports;
- a sign extender;
- a main decoder, which turns the opcode into control lines;
- a secondary decoder, which picks the arithmetic operation from the function code;
- the arithmetic unit;
- two dedicated adders for the sequential address and the branch address, so that the next program counter is settled within the cycle.

Nine instructions are supported: word load, word store, add, subtract, bitwise AND, bitwise OR, signed set-less-than, branch-if-equal and an absolute jump. Any other encoding retires as a no-operation.

Top module: `onecycle_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter is loaded with 0. After that edge, `imem_addr` reads 0.
- R2: Every instruction that is neither a taken branch nor a jump advances `imem_addr` by 4 at the next edge.
- R3: Instruction fields sit at fixed positions: op [31:26], rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. Opcode 000000 selects a register-to-register operation, and its result is written to register rd. The funct code chooses the operation:
  - 100000 adds;
  - 100010 subtracts;
  - 100100 takes the bitwise AND;
  - 100101 takes the bitwise OR;
  - 101010 gives 1 if rs is less than rt as signed values, and 0 otherwise.
- R4: Opcode 100011 loads the data word at address rs + sext(instr[15:0]) into register rt. A negative offset is handled as a negative number.
- R5: Opcode 101011 raises `dmem_we` for one cycle. It puts rs + sext(instr[15:0]) on `dmem_addr` and register rt on `dmem_wdata`. No other opcode raises `dmem_we`.
- R6: Opcode 000100 compares rs and rt. If they are equal, the next address is PC + 4 + (sext(instr[15:0]) << 2), and a negative offset branches backwards. If they are not equal, the next address is PC + 4.
- R7: Opcode 000010 jumps to {PC+4 [31:28], instr[25:0], 2'b00}.
- R8: Register 0 always reads as zero, even after an instruction names it as its destination.
- R9: Any opcode not listed in R3 to R7 writes no register and no memory, and advances the program counter by 4. A register-to-register opcode with an unlisted funct code also writes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the program counter |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; memory writes at the clock edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |

## Verification
The assertions rely on three things about the inputs:
- `imem_data` carries a defined word in every cycle after reset;
- instruction memory answers the exact word at the aligned address that the core presents;
- a reset lasts at least one full clock edge.

The bench keeps within these limits in the following ways:
- It fills the whole instruction array with defined words, and the program ends in a branch that loops on itself, so fetches never leave the loaded region.
- It models both memories as word-indexed arrays that answer combinationally.
- It holds reset high across two edges before it releases reset just after a rising edge.

// File: rtl/onecycle_core.sv
module onecycle_core #(
  parameter int          NREGS    = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam int RW = $clog2(NREGS);

  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {CLS_ADD, CLS_SUB, CLS_FUNCT} alu_class_t;
  typedef enum logic [2:0] {SEL_ADD, SEL_SUB, SEL_AND, SEL_OR, SEL_SLT} alu_sel_t;

  logic [31:0] pc;
  logic [31:0] regs [NREGS];

  wire [5:0]  op    = imem_data[31:26];
  wire [4:0]  rs    = imem_data[25:21];
  wire [4:0]  rt    = imem_data[20:16];
  wire [4:0]  rd    = imem_data[15:11];
  wire [5:0]  funct = imem_data[5:0];
  wire [31:0] simm  = {{16{imem_data[15]}}, imem_data[15:0]};

  // main decoder
  logic       dst_is_rd, b_is_imm, wb_from_mem, wr_reg, wr_mem, is_beq, is_jump;
  alu_class_t alu_class;

  always_comb begin
    dst_is_rd   = 1'b0;
    b_is_imm    = 1'b0;
    wb_from_mem = 1'b0;
    wr_reg      = 1'b0;
    wr_mem      = 1'b0;
    is_beq      = 1'b0;
    is_jump     = 1'b0;
    alu_class   = CLS_ADD;
    case (op)
      OP_REG:   begin dst_is_rd = 1'b1; wr_reg = 1'b1; alu_class = CLS_FUNCT; end
      OP_LOAD:  begin b_is_imm = 1'b1; wb_from_mem = 1'b1; wr_reg = 1'b1; end
      OP_STORE: begin b_is_imm = 1'b1; wr_mem = 1'b1; end
      OP_BEQ:   begin is_beq = 1'b1; alu_class = CLS_SUB; end
      OP_JUMP:  is_jump = 1'b1;
      default:  ;
    endcase
  end

  // ALU control decoder
  alu_sel_t alu_sel;
  logic     funct_ok;

  always_comb begin
    alu_sel  = SEL_ADD;
    funct_ok = 1'b1;
    case (alu_class)
      CLS_SUB: alu_sel = SEL_SUB;
      CLS_FUNCT:
        case (funct)
          FN_ADD:  alu_sel = SEL_ADD;
          FN_SUB:  alu_sel = SEL_SUB;
          FN_AND:  alu_sel = SEL_AND;
          FN_OR:   alu_sel = SEL_OR;
          FN_SLT:  alu_sel = SEL_SLT;
          default: funct_ok = 1'b0;
        endcase
      default: alu_sel = SEL_ADD;
    endcase
  end

  // register file reads
  wire [31:0] rdata_a = (rs == 5'd0) ? 32'd0 : regs[rs[RW-1:0]];
  wire [31:0] rdata_b = (rt == 5'd0) ? 32'd0 : regs[rt[RW-1:0]];

  // ALU
  wire [31:0] opnd_b = b_is_imm ? simm : rdata_b;
  logic [31:0] alu_y;

  always_comb begin
    case (alu_sel)
      SEL_SUB: alu_y = rdata_a - opnd_b;
      SEL_AND: alu_y = rdata_a & opnd_b;
      SEL_OR:  alu_y = rdata_a | opnd_b;
      SEL_SLT: alu_y = {31'd0, $signed(rdata_a) < $signed(opnd_b)};
      default: alu_y = rdata_a + opnd_b;
    endcase
  end

  wire alu_zero = (alu_y == 32'd0);

  // write-back
  wire [4:0]  wb_addr = dst_is_rd ? rd : rt;
  wire [31:0] wb_data = wb_from_mem ? dmem_rdata : alu_y;
  wire        wb_en   = wr_reg && funct_ok && (wb_addr != 5'd0);

  always_ff @(posedge clk)
    if (wb_en) regs[wb_addr[RW-1:0]] <= wb_data;

  // next program counter
  wire [31:0] pc_seq  = pc + 32'd4;
  wire [31:0] pc_br   = pc_seq + {simm[29:0], 2'b00};
  wire [31:0] pc_jmp  = {pc_seq[31:28], imem_data[25:0], 2'b00};
  wire [31:0] pc_next = is_jump ? pc_jmp : (is_beq && alu_zero) ? pc_br : pc_seq;

  always_ff @(posedge clk)
    if (rst) pc <= RESET_PC;
    else     pc <= pc_next;

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rdata_b;
  assign dmem_we    = wr_mem;
endmodule

module onecycle_core_chk #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_data,
  input logic        dmem_we
);
  wire [5:0]  op     = imem_data[31:26];
  wire [31:0] jdest  = {imem_addr[31:28] + {3'd0, &imem_addr[27:2]}, imem_data[25:0], 2'b00};
  wire        listed = (op == 6'b000000) || (op == 6'b100011) || (op == 6'b101011) ||
                       (op == 6'b000100) || (op == 6'b000010);

  assert_pc_reset_R1: assert property (@(posedge clk) rst |=> imem_addr == RESET_PC);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (op != 6'b000100 && op != 6'b000010) |=> imem_addr == $past(imem_addr) + 32'd4);

  assert_store_only_R5: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == 6'b101011);

  assert_jump_dest_R7: assert property (@(posedge clk) disable iff (rst)
    op == 6'b000010 |=> imem_addr == $past(jdest));

  assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !listed |-> !dmem_we);
endmodule

bind onecycle_core onecycle_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data), .dmem_we(dmem_we)
);

// File: tb/onecycle_core_test.sv
module onecycle_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  always #10 clk = ~clk;

  onecycle_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } item_t;

  item_t pc_q[$];
  item_t wr_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    running = 1'b0;

  function automatic logic [31:0] rop(int s, int t, int d, logic [5:0] fn);
    return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] iop(logic [5:0] o, int s, int t, int imm);
    return {o, 5'(s), 5'(t), 16'(imm)};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_pc(logic [31:0] a, string tag);
    item_t it;
    it.a = a; it.d = 32'd0; it.tag = tag;
    pc_q.push_back(it);
  endtask
  task automatic expect_wr(logic [31:0] a, logic [31:0] d, string tag);
    item_t it;
    it.a = a; it.d = d; it.tag = tag;
    wr_q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (running) begin
      if (pc_q.size() > 0) begin
        item_t e;
        e = pc_q.pop_front();
        check(imem_addr == e.a, e.tag, imem_addr, e.a);
      end
      if (dmem_we) begin
        if (wr_q.size() > 0) begin
          item_t w;
          w = wr_q.pop_front();
          check(dmem_addr == w.a, {w.tag, " store address"}, dmem_addr, w.a);
          check(dmem_wdata == w.d, {w.tag, " store data"}, dmem_wdata, w.d);
        end else begin
          check(1'b0, "R5 R9 unexpected store", dmem_addr, 32'hxxxx_xxxx);
        end
      end
    end
  end

  localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100, JMP = 6'b000010;

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = 32'd0; dmem[i] = 32'd0; end
    dmem[0] = 32'd7; dmem[1] = 32'd5; dmem[2] = 32'd12;

    imem[0]  = iop(LW, 0, 1, 0);
    imem[1]  = iop(LW, 0, 2, 4);
    imem[2]  = rop(1, 2, 3, 6'b100000);
    imem[3]  = iop(SW, 0, 3, 16);
    imem[4]  = rop(1, 2, 4, 6'b100010);
    imem[5]  = iop(SW, 0, 4, 20);
    imem[6]  = rop(1, 2, 5, 6'b100100);
    imem[7]  = rop(1, 2, 6, 6'b100101);
    imem[8]  = iop(SW, 0, 5, 24);
    imem[9]  = iop(SW, 0, 6, 28);
    imem[10] = rop(2, 1, 7, 6'b101010);
    imem[11] = rop(1, 2, 8, 6'b101010);
    imem[12] = iop(SW, 0, 7, 32);
    imem[13] = iop(SW, 0, 8, 36);
    imem[14] = rop(1, 1, 0, 6'b100000);
    imem[15] = iop(SW, 0, 0, 40);
    imem[16] = iop(BEQ, 1, 2, 5);
    imem[17] = iop(BEQ, 1, 1, 2);
    imem[18] = iop(SW, 0, 1, 44);
    imem[19] = iop(SW, 0, 1, 48);
    imem[20] = iop(6'b111111, 0, 1, 4);
    imem[21] = iop(SW, 0, 1, 52);
    imem[22] = iop(LW, 0, 10, 8);
    imem[23] = iop(LW, 10, 9, -8);
    imem[24] = iop(SW, 0, 9, 56);
    imem[25] = {JMP, 26'd28};
    imem[26] = iop(SW, 0, 1, 60);
    imem[27] = iop(SW, 0, 1, 60);
    imem[28] = iop(BEQ, 0, 0, -1);

    for (int a = 0; a <= 68; a += 4) expect_pc(32'(a), "R2 sequential fetch");
    expect_pc(32'd80, "R6 taken branch forward");
    for (int a = 84; a <= 100; a += 4) expect_pc(32'(a), "R2 R9 fetch after no-op");
    expect_pc(32'd112, "R7 jump target");
    expect_pc(32'd112, "R6 backward branch to itself");
    expect_pc(32'd112, "R6 backward branch to itself");

    expect_wr(32'd16, 32'd12, "R3 R4 R5 add of loaded words");
    expect_wr(32'd20, 32'd2,  "R3 sub");
    expect_wr(32'd24, 32'd5,  "R3 and");
    expect_wr(32'd28, 32'd7,  "R3 or");
    expect_wr(32'd32, 32'd1,  "R3 slt true");
    expect_wr(32'd36, 32'd0,  "R3 slt false");
    expect_wr(32'd40, 32'd0,  "R8 register zero after write");
    expect_wr(32'd52, 32'd7,  "R9 unknown opcode left rt intact");
    expect_wr(32'd56, 32'd5,  "R4 negative load offset");

    repeat (2) @(posedge clk);
    @(negedge clk);
    check(imem_addr == 32'd0, "R1 reset pc", imem_addr, 32'd0);
    check(dmem_we == 1'b0, "R5 no store during reset", {31'd0, dmem_we}, 32'd0);
    @(posedge clk);
    #1 rst = 1'b0; running = 1'b1;

    begin
      int n = 0;
      while ((pc_q.size() > 0 || wr_q.size() > 0) && n < 2000) begin
        @(posedge clk);
        n++;
      end
      if (n >= 2000) check(1'b0, "watchdog expired", 32'(n), 32'd2000);
    end
    @(negedge clk);
    running = 1'b0;
    check(dmem[11] == 32'd0, "R6 skipped store at 44", dmem[11], 32'd0);
    check(dmem[12] == 32'd0, "R6 skipped store at 48", dmem[12], 32'd0);
    check(dmem[15] == 32'd0, "R7 skipped store at 60", dmem[15], 32'd0);
    check(wr_q.size() == 0, "R5 all stores seen", 32'(wr_q.size()), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule